// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The block turns edges on general-purpose input pins into interrupt requests and event pulses for sixteen interrupt lines. Each line picks one of up to nine input ports through its own 4-bit selector. The chosen pin is synchronized and then edge-detected. Enabled edges set a per-line pending flag. That flag is held until software clears it, whatever the line's interrupt mask says.

Software programs the block through a small register bus: a write strobe, a 4-bit address, 16-bit write data, and read data driven combinationally from the address. The lines have separate rising and falling edge enables, an interrupt mask and an event mask. Software can also force a line pending, and clears pending flags by writing ones. Lines 0 to 4 each drive a dedicated request output. Lines 5 to 9 share one request output and lines 10 to 15 share another. Every line also has a single-cycle event output.

Top module: `extLineIrqCtrl`

## Requirements
- R1: Line y takes its input from pin `portPins[p*16+y]`, where p is the 4-bit selector held in bits [4*(y%4)+3 : 4*(y%4)] of the port-select register at address 8+y/4. Selector value 0 means port A, 1 means port B and so on up to 8 for port I. Values 9 to 15 hold the line low. A pin on a port that is not selected has no effect on the line.
- R2: The rising-enable register (address 0) and the falling-enable register (address 1) act independently for each line. When a line has both bits set, it responds to either edge.
- R3: An enabled edge on a line's selected pin sets the line's bit in the pending register (address 5). If the pin changes before clock edge k, the pending bit and the event pulse become visible after clock edge k+2.
- R4: Writing 1 to a bit of the pending register clears that bit. Writing 0 to a bit leaves it unchanged.
- R5: A pending bit latches even when the line's interrupt mask bit (address 2) is 0. Setting the mask bit of an already pending line raises its request in the cycle after the write.
- R6: Writing 1 to a bit of the software-trigger register (address 4) sets that line's pending bit in the same clock edge. A read of this register returns 0.
- R7: `irqReq[i]` is pending AND interrupt mask of line i, for i from 0 to 4. `irqReq[5]` is the OR of that product over lines 5 to 9, and `irqReq[6]` is the OR over lines 10 to 15.
- R8: `evtPulse[y]` is high for exactly one cycle for each enabled edge on line y while the line's event mask bit (address 3) is 1. It does not depend on the pending bit or the interrupt mask, and a software trigger produces no event pulse.
- R9: If a clear write and a new enabled edge hit the same line in the same cycle, the pending bit stays set.
- R10: After reset, all registers read 0, every line selects port A, and `irqReq` and `evtPulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address, used for both reads and writes |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `regAddr` (combinational) |
| portPins | input | 144 | Pin inputs; port p line y at bit p*16+y |
| irqReq | output | 7 | Interrupt requests: 0 to 4 dedicated, 5 for lines 5 to 9, 6 for lines 10 to 15 |
| evtPulse | output | 16 | Single-cycle event pulse for each line |

## Verification
The assertions assume that pins are low and the write strobe is idle during reset. They also assume that every pending change comes from a detected edge, a software trigger or a clear write. Rewriting a selector can create an edge inside the multiplexer, because the newly selected pin may differ from the old one. The properties accept this as a real edge. To keep the scoreboard consistent, the stimulus waits a few cycles after every selector rewrite and then clears all pending flags before it compares again. In the random phase only one pin toggles at a time, and each toggle is followed by enough cycles for the synchronizer to settle.

// File: rtl/extIrqPkg.sv
package extIrqPkg;
  localparam int LINES    = 16;
  localparam int SEL_W    = 4;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 4;
  localparam int SEL_REGS = LINES * SEL_W / DATA_W;
  localparam int DEDICATED = 5;
  localparam int GRP_A_HI  = 9;
  localparam int IRQ_OUTS  = DEDICATED + 2;

  localparam logic [ADDR_W-1:0] ADDR_RISE   = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_FALL   = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_IMASK  = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_EMASK  = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_SWTRIG = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_PEND   = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_SEL0   = 4'd8;

  typedef struct packed {
    logic [LINES-1:0] clrMask;
    logic [LINES-1:0] setMask;
  } strobeT;
endpackage

// File: rtl/extIrqRegs.sv
module extIrqRegs
  import extIrqPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [LINES-1:0]        pendQ,
  output logic [DATA_W-1:0]       rdData,
  output logic [LINES-1:0]        riseSel,
  output logic [LINES-1:0]        fallSel,
  output logic [LINES-1:0]        irqMask,
  output logic [LINES-1:0]        evtMask,
  output logic [LINES*SEL_W-1:0]  selFlat,
  output strobeT                  strb
);
  logic [DATA_W-1:0] selRegQ [SEL_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseSel <= '0;
      fallSel <= '0;
      irqMask <= '0;
      evtMask <= '0;
    end else if (wrEn) begin
      case (regAddr)
        ADDR_RISE:  riseSel <= wrData;
        ADDR_FALL:  fallSel <= wrData;
        ADDR_IMASK: irqMask <= wrData;
        ADDR_EMASK: evtMask <= wrData;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < SEL_REGS; g++) begin : gSel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) selRegQ[g] <= '0;
      else if (wrEn && regAddr == ADDR_SEL0 + ADDR_W'(g)) selRegQ[g] <= wrData;
    end
    assign selFlat[g*DATA_W +: DATA_W] = selRegQ[g];
  end

  always_comb begin
    strb.setMask = (wrEn && regAddr == ADDR_SWTRIG) ? wrData : '0;
    strb.clrMask = (wrEn && regAddr == ADDR_PEND)   ? wrData : '0;
  end

  always_comb begin
    case (regAddr)
      ADDR_RISE:  rdData = riseSel;
      ADDR_FALL:  rdData = fallSel;
      ADDR_IMASK: rdData = irqMask;
      ADDR_EMASK: rdData = evtMask;
      ADDR_PEND:  rdData = pendQ;
      default:    rdData = (regAddr[ADDR_W-1:2] == ADDR_SEL0[ADDR_W-1:2])
                           ? selRegQ[regAddr[1:0]] : '0;
    endcase
  end
endmodule

// File: rtl/extIrqPath.sv
module extIrqPath
  import extIrqPkg::*;
#(
  parameter int NUM_PORTS   = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PORTS*LINES-1:0] portPins,
  input  logic [LINES*SEL_W-1:0]     selFlat,
  input  logic [LINES-1:0]           riseSel,
  input  logic [LINES-1:0]           fallSel,
  input  logic [LINES-1:0]           irqMask,
  input  logic [LINES-1:0]           evtMask,
  input  strobeT                     strb,
  output logic [LINES-1:0]           pendQ,
  output logic [LINES-1:0]           hitVec,
  output logic [IRQ_OUTS-1:0]        irqReq,
  output logic [LINES-1:0]           evtPulse
);
  logic [LINES-1:0] lineRaw;
  logic [LINES-1:0] syncQ [SYNC_STAGES];
  logic [LINES-1:0] prevQ;
  logic [LINES-1:0] lineNow;
  logic [LINES-1:0] active;

  for (genvar y = 0; y < LINES; y++) begin : gMux
    logic [SEL_W-1:0] selY;
    assign selY = selFlat[y*SEL_W +: SEL_W];
    assign lineRaw[y] = (int'(selY) < NUM_PORTS) ? portPins[int'(selY)*LINES + y] : 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= lineRaw;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign lineNow = syncQ[SYNC_STAGES-1];
  assign hitVec  = (lineNow & ~prevQ & riseSel) | (~lineNow & prevQ & fallSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= '0;
      evtPulse <= '0;
    end else begin
      pendQ    <= (pendQ & ~strb.clrMask) | hitVec | strb.setMask;
      evtPulse <= hitVec & evtMask;
    end
  end

  assign active = pendQ & irqMask;

  for (genvar i = 0; i < DEDICATED; i++) begin : gDed
    assign irqReq[i] = active[i];
  end
  assign irqReq[DEDICATED]   = |active[GRP_A_HI:DEDICATED];
  assign irqReq[DEDICATED+1] = |active[LINES-1:GRP_A_HI+1];
endmodule

// File: rtl/extLineIrqCtrl.sv
module extLineIrqCtrl
  import extIrqPkg::*;
#(
  parameter int NUM_PORTS   = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  input  logic [NUM_PORTS*LINES-1:0] portPins,
  output logic [IRQ_OUTS-1:0]        irqReq,
  output logic [LINES-1:0]           evtPulse
);
  logic [LINES-1:0]       pendQ;
  logic [LINES-1:0]       hitVec;
  logic [LINES-1:0]       riseQ, fallQ, irqMaskQ, evtMaskQ;
  logic [LINES*SEL_W-1:0] selFlat;
  strobeT                 strb;

  extIrqRegs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .pendQ(pendQ), .rdData(rdData), .riseSel(riseQ), .fallSel(fallQ),
    .irqMask(irqMaskQ), .evtMask(evtMaskQ), .selFlat(selFlat), .strb(strb)
  );

  extIrqPath #(.NUM_PORTS(NUM_PORTS), .SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk(clk), .rstN(rstN), .portPins(portPins), .selFlat(selFlat),
    .riseSel(riseQ), .fallSel(fallQ), .irqMask(irqMaskQ), .evtMask(evtMaskQ),
    .strb(strb), .pendQ(pendQ), .hitVec(hitVec), .irqReq(irqReq), .evtPulse(evtPulse)
  );
endmodule

// File: rtl/extIrqChk.sv
module extIrqChk
  import extIrqPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [LINES-1:0]    pendQ,
  input logic [LINES-1:0]    hitVec,
  input strobeT              strb,
  input logic [LINES-1:0]    irqMaskQ,
  input logic [LINES-1:0]    evtMaskQ,
  input logic [IRQ_OUTS-1:0] irqReq,
  input logic [LINES-1:0]    evtPulse
);
  // R3 R6
  pend_set_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & ~$past(pendQ) & ~$past(hitVec | strb.setMask)) == '0));

  // R4
  pend_clr_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(pendQ) & ~pendQ & ~$past(strb.clrMask)) == '0));

  // R9
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(hitVec) & ~pendQ) == '0));

  // R8
  evt_needs_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((evtPulse & ~$past(evtMaskQ)) == '0));

  // R8
  evt_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((evtPulse & ~$past(hitVec)) == '0));

  // R7
  shared_hi_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq[DEDICATED+1] == |(pendQ[LINES-1:GRP_A_HI+1] & irqMaskQ[LINES-1:GRP_A_HI+1]));

  // R7
  shared_lo_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq[DEDICATED] == |(pendQ[GRP_A_HI:DEDICATED] & irqMaskQ[GRP_A_HI:DEDICATED]));
endmodule

bind extLineIrqCtrl extIrqChk u_chk (
  .clk(clk), .rstN(rstN), .pendQ(pendQ), .hitVec(hitVec), .strb(strb),
  .irqMaskQ(irqMaskQ), .evtMaskQ(evtMaskQ), .irqReq(irqReq), .evtPulse(evtPulse)
);

// File: tb/extLineIrqCtrl_tb.sv
module extLineIrqCtrl_tb;
  import extIrqPkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [15:0] wrData = '0;
  logic [NPORT*16-1:0] pins = '0;
  logic [15:0] rdData;
  logic [6:0] irqReq;
  logic [15:0] evtPulse;

  int total = 0;
  int bad = 0;

  logic [15:0] mRise = '0, mFall = '0, mIm = '0, mEm = '0, mPend = '0;
  logic [3:0]  mSel [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  extLineIrqCtrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .portPins(pins), .irqReq(irqReq), .evtPulse(evtPulse)
  );

  function automatic logic [6:0] expIrq(input logic [15:0] p, input logic [15:0] m);
    logic [15:0] a;
    a = p & m;
    return {|a[15:10], |a[9:5], a[4:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      ADDR_RISE:   mRise = d;
      ADDR_FALL:   mFall = d;
      ADDR_IMASK:  mIm = d;
      ADDR_EMASK:  mEm = d;
      ADDR_SWTRIG: mPend = mPend | d;
      ADDR_PEND:   mPend = mPend & ~d;
      default:
        if (a >= 4'd8 && a <= 4'd11)
          for (int k = 0; k < 4; k++) mSel[(a-8)*4+k] = d[k*4 +: 4];
    endcase
  endtask

  task automatic checkState(input string req);
    logic [15:0] d;
    rd(ADDR_PEND, d);
    check({req, " pending"}, d, mPend);
    check({req, " irq"}, irqReq, expIrq(mPend, mIm));
  endtask

  // One pin change; checks the event pulse at the cycle R3 names and its drop one cycle later.
  task automatic pinOp(input int p, input int y, input logic v);
    logic old;
    logic [15:0] hit;
    @(negedge clk);
    old = pins[p*16+y];
    hit = '0;
    if (int'(mSel[y]) == p && old != v) hit[y] = v ? mRise[y] : mFall[y];
    pins[p*16+y] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 event pulse", evtPulse, hit & mEm);
    mPend = mPend | hit;
    checkState("R3");
    @(negedge clk);
    check("R8 single cycle", evtPulse, 16'h0);
  endtask

  task automatic settleAndClear();
    repeat (5) @(negedge clk);
    wr(ADDR_PEND, 16'hFFFF);
    checkState("R4 cleanup");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mSel[i] = '0;
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 irq", irqReq, 7'h0);
    check("R10 evt", evtPulse, 16'h0);
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), d);
      check("R10 reg", d, 16'h0);
    end

    // R1 R2 R7: line 13 on port C, falling only, unmasked
    wr(ADDR_FALL, 16'h2000);
    wr(ADDR_IMASK, 16'h2000);
    wr(ADDR_SEL0 + 4'd3, 16'h0020);
    rd(ADDR_SEL0 + 4'd3, d);
    check("R1 select readback", d, 16'h0020);
    pinOp(0, 13, 1'b1);
    pinOp(0, 13, 1'b0);
    check("R1 unselected port ignored", irqReq, 7'h0);
    pinOp(2, 13, 1'b1);
    check("R2 rising not enabled", irqReq, 7'h0);
    pinOp(2, 13, 1'b0);
    check("R1 port C drives line 13", irqReq, 7'h40);
    check("R7 shared line 10-15", irqReq[6], 1'b1);

    // R4 write-one-to-clear
    wr(ADDR_PEND, 16'h0000);
    checkState("R4 zero write");
    check("R4 still set", mPend, 16'h2000);
    wr(ADDR_PEND, 16'h2000);
    checkState("R4 cleared");
    check("R4 irq gone", irqReq, 7'h0);

    // R5 latch while masked, then unmask
    wr(ADDR_RISE, 16'h0005);
    pinOp(0, 2, 1'b1);
    check("R5 masked no irq", irqReq, 7'h0);
    wr(ADDR_IMASK, 16'h2004);
    check("R5 unmask raises irq", irqReq, 7'h04);

    // R6 software trigger, R7 shared 5-9
    wr(ADDR_IMASK, 16'h2084);
    wr(ADDR_SWTRIG, 16'h0080);
    check("R8 no event on sw trigger", evtPulse, 16'h0);
    checkState("R6");
    check("R7 shared line 5-9", irqReq, 7'h24);
    rd(ADDR_SWTRIG, d);
    check("R6 reads zero", d, 16'h0);

    // R8 event only on line 0
    wr(ADDR_EMASK, 16'h0001);
    pinOp(0, 0, 1'b1);
    check("R8 no irq from event line", irqReq[0], 1'b0);
    pinOp(0, 0, 1'b0);

    // R2 either edge on line 3
    wr(ADDR_RISE, 16'h000D);
    wr(ADDR_FALL, 16'h2008);
    pinOp(0, 3, 1'b1);
    check("R2 rise sets", mPend[3], 1'b1);
    wr(ADDR_PEND, 16'h0008);
    pinOp(0, 3, 1'b0);
    check("R2 fall sets", mPend[3], 1'b1);

    // R9 clear and edge in the same cycle on line 0
    wr(ADDR_EMASK, 16'h0000);
    wr(ADDR_SWTRIG, 16'h0001);
    @(negedge clk);
    pins[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    regAddr = ADDR_PEND; wrData = 16'h0001; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    rd(ADDR_PEND, d);
    check("R9 edge wins", d[0], 1'b1);
    pins[0] = 1'b0;
    settleAndClear();

    // Random phase
    for (int r = 0; r < 4; r++) begin
      wr(ADDR_RISE,  16'($urandom));
      wr(ADDR_FALL,  16'($urandom));
      wr(ADDR_IMASK, 16'($urandom));
      wr(ADDR_EMASK, 16'($urandom));
      for (int s = 0; s < 4; s++) begin
        logic [15:0] sv;
        for (int k = 0; k < 4; k++) sv[k*4 +: 4] = 4'($urandom % NPORT);
        wr(ADDR_SEL0 + 4'(s), sv);
      end
      settleAndClear();
      for (int n = 0; n < 60; n++) begin
        case ($urandom % 4)
          0, 1: begin
            int p, y;
            p = int'($urandom % NPORT);
            y = int'($urandom % 16);
            pinOp(p, y, ~pins[p*16+y]);
          end
          2: begin
            wr(ADDR_PEND, 16'($urandom));
            checkState("R4 random clear");
          end
          default: begin
            wr(ADDR_SWTRIG, 16'($urandom) & 16'($urandom));
            checkState("R6 random trigger");
          end
        endcase
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule